// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Resolver

This block keeps a two-bit status record for each peripheral on an interrupt daisy chain and decides which device gets the next maskable interrupt and which device is in service. Each peripheral reports changes to its own record through a single write port. A write carries a slot index and a status pair: one bit asks for service, the other marks the device as in service. A device that is in service blocks lower-ranked devices from the chain.

After a write that changes a record, the block scans the table from slot 0 upwards. A requesting slot replaces any requester found before it. An in-service slot discards any requester found before it and becomes the reported in-service device. The result is registered, so the requester index, the in-service index and the pending flag for the CPU appear one clock after the write. When the CPU acknowledges, the granted request is withdrawn. A clear command empties the whole table at once.

Top module: `irq_chain_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, every slot record is zeroed and `req_valid`, `ins_valid` and `irq_pending` are 0 after that edge.
- R2: A write (`wr_en`=1) to an in-range slot whose `wr_status` (bit 0 = request, bit 1 = in service) differs from the stored record stores it, and the rescanned outputs appear after that same clock edge.
- R3: A write whose status equals the stored record causes no rescan: every output keeps its value.
- R4: The scan runs in ascending slot order. Among requesters not masked by an in-service slot, the one with the highest index is reported in `req_idx` with `req_valid`=1.
- R5: An in-service slot cancels every requester at a lower index. The highest-index in-service slot is reported in `ins_idx` with `ins_valid`=1.
- R6: A slot that has both bits set is reported as requester and as in-service device, unless a later slot overrides it.
- R7: After a rescan, `irq_pending` equals `req_valid`. `irq_pending` is never 1 while `req_valid` is 0.
- R8: `clear_all` zeroes every record and drives `irq_pending` and `ins_valid` to 0 after the edge. The requester output is left as it was. A write in the same cycle is discarded.
- R9: `ack` drives `req_valid` and `irq_pending` to 0 after the edge and leaves the records unchanged. A status-changing write in the same cycle takes precedence, and its rescan result is shown.
- R10: A write with `wr_idx` at or above `NUM_SLOTS` changes no record and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Status write strobe |
| wr_idx | input | ADDR_W | Slot addressed by the write |
| wr_status | input | 2 | New record: bit 0 request, bit 1 in service |
| clear_all | input | 1 | Zero all records and drop pending |
| ack | input | 1 | CPU acknowledge of the maskable interrupt |
| req_valid | output | 1 | A requester is granted |
| req_idx | output | SLOT_W | Index of the granted requester |
| ins_valid | output | 1 | A device is in service |
| ins_idx | output | SLOT_W | Index of the in-service device |
| irq_pending | output | 1 | Maskable interrupt pending to the CPU |

## Verification
The CPU acknowledge and a status-changing write can land in the same cycle, and so can `clear_all` and a write. The bench forces both pairs on purpose, in directed steps and throughout a long random run in which every input is toggled independently. The behavioural model resolves each collision by the stated precedence: a rescan beats the acknowledge, and clear beats the write. A stale index or pending flag after the collision is caught on the next compare.

// File: rtl/irq_chain_pkg.sv
// Shared types for the daisy-chain interrupt resolver.
// Assumes: the status pair is always handled as one two-bit record.
package irq_chain_pkg;

    // One chain slot: in-service flag above request flag (bit 0 = request).
    typedef struct packed {
        logic ins;
        logic req;
    } slot_stat_t;

endpackage

// File: rtl/irq_slot_table.sv
// Per-slot status storage with change detection.
// Applies one write per cycle. Flags a rescan only when the addressed record
// actually changes. Drops writes to indices at or above NUM_SLOTS.
// Assumes ADDR_W >= SLOT_W.
module irq_slot_table
    import irq_chain_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 3,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_idx,
    input  slot_stat_t                    wr_status,
    input  logic                          clear_all,
    output slot_stat_t [NUM_SLOTS-1:0]    table_q,
    output slot_stat_t [NUM_SLOTS-1:0]    table_nx,
    output logic                          reeval
);

    localparam logic [ADDR_W:0] SLOT_LIMIT = (ADDR_W+1)'(NUM_SLOTS);

    logic              in_range;
    logic [SLOT_W-1:0] slot_sel;

    // Decode the write address and detect a real change of the record.
    assign in_range = ({1'b0, wr_idx} < SLOT_LIMIT);
    assign slot_sel = wr_idx[SLOT_W-1:0];
    assign reeval   = wr_en && in_range && !clear_all && (table_q[slot_sel] != wr_status);

    // Next-table view: the addressed slot takes the written record.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign table_nx[g] = (wr_en && in_range && (slot_sel == SLOT_W'(g)))
                             ? wr_status : table_q[g];
    end

    // Record storage: reset and clear empty it, a changing write updates it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            table_q <= '0;
        end else if (reeval) begin
            table_q <= table_nx;
        end
    end

    // R10: an out-of-range write leaves every record untouched.
    a_r10_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range && !clear_all) |=> $stable(table_q));

    // R8: clear leaves an empty table.
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (table_q == '0));

endmodule

// File: rtl/irq_priority_scan.sv
// Ordered priority scan over the slot records.
// Walks slots from 0 upwards. A request takes the requester position, and an
// in-service flag first drops any earlier requester and takes the in-service
// position. Purely combinational.
module irq_priority_scan
    import irq_chain_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  slot_stat_t [NUM_SLOTS-1:0] table_in,
    output logic                       req_v,
    output logic [SLOT_W-1:0]          req_i,
    output logic                       ins_v,
    output logic [SLOT_W-1:0]          ins_i
);

    // Single ascending pass; later slots override earlier findings.
    always_comb begin
        req_v = 1'b0;
        req_i = '0;
        ins_v = 1'b0;
        ins_i = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (table_in[s].ins) begin
                req_v = 1'b0;
                ins_v = 1'b1;
                ins_i = SLOT_W'(s);
            end
            if (table_in[s].req) begin
                req_v = 1'b1;
                req_i = SLOT_W'(s);
            end
        end
    end

endmodule

// File: rtl/irq_chain_resolver.sv
// Daisy-chain interrupt priority resolver, top level.
// Holds the result registers for the requester, the in-service device and the
// pending flag. A changing status write reloads them from the scan of the
// next-cycle table. Clear and acknowledge drop parts of the result.
// Assumes one write per cycle and ADDR_W >= SLOT_W.
module irq_chain_resolver
    import irq_chain_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 3,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [1:0]        wr_status,
    input  logic              clear_all,
    input  logic              ack,
    output logic              req_valid,
    output logic [SLOT_W-1:0] req_idx,
    output logic              ins_valid,
    output logic [SLOT_W-1:0] ins_idx,
    output logic              irq_pending
);

    slot_stat_t [NUM_SLOTS-1:0] table_q;
    slot_stat_t [NUM_SLOTS-1:0] table_nx;
    logic                       reeval;
    logic                       scan_rv;
    logic                       scan_iv;
    logic [SLOT_W-1:0]          scan_ri;
    logic [SLOT_W-1:0]          scan_ii;

    irq_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .SLOT_W    (SLOT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_status (slot_stat_t'(wr_status)),
        .clear_all (clear_all),
        .table_q   (table_q),
        .table_nx  (table_nx),
        .reeval    (reeval)
    );

    irq_priority_scan #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_scan (
        .table_in (table_nx),
        .req_v    (scan_rv),
        .req_i    (scan_ri),
        .ins_v    (scan_iv),
        .ins_i    (scan_ii)
    );

    // Result registers: reset, then clear, then rescan, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid   <= 1'b0;
            req_idx     <= '0;
            ins_valid   <= 1'b0;
            ins_idx     <= '0;
            irq_pending <= 1'b0;
        end else if (clear_all) begin
            ins_valid   <= 1'b0;
            irq_pending <= 1'b0;
            if (ack) begin
                req_valid <= 1'b0;
            end
        end else if (reeval) begin
            req_valid   <= scan_rv;
            req_idx     <= scan_ri;
            ins_valid   <= scan_iv;
            ins_idx     <= scan_ii;
            irq_pending <= scan_rv;
        end else if (ack) begin
            req_valid   <= 1'b0;
            irq_pending <= 1'b0;
        end
    end

    // R7: a pending interrupt always has a requester behind it.
    a_r7_pending_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> req_valid);

    // R5: a reported requester never sits below the in-service device.
    a_r5_req_above_ins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ins_valid) |-> (req_idx >= ins_idx));

    // R3: with no rescan, clear or acknowledge, the outputs hold.
    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reeval && !clear_all && !ack) |=>
        $stable({req_valid, req_idx, ins_valid, ins_idx, irq_pending}));

    // R9: an acknowledge without a rescan withdraws the grant.
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reeval && !clear_all) |=> (!req_valid && !irq_pending));

    // R8: clear drops pending and in-service.
    a_r8_clear_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (!irq_pending && !ins_valid));

endmodule

// File: tb/irq_chain_resolver_tb.sv
`timescale 1ns/1ps
module irq_chain_resolver_tb_top;

    localparam int NS  = 4;
    localparam int AW  = 3;
    localparam int SW  = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [1:0]    wr_status;
    logic          clear_all;
    logic          ack;
    logic          req_valid;
    logic [SW-1:0] req_idx;
    logic          ins_valid;
    logic [SW-1:0] ins_idx;
    logic          irq_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference state.
    bit m_req [NS];
    bit m_ins [NS];
    bit m_rv, m_iv, m_pend;
    int m_ri, m_ii;

    always #2.5 clk = ~clk;

    irq_chain_resolver #(.NUM_SLOTS(NS), .ADDR_W(AW)) dut_i (
        .clk, .rst_n, .wr_en, .wr_idx, .wr_status, .clear_all, .ack,
        .req_valid, .req_idx, .ins_valid, .ins_idx, .irq_pending
    );

    // Advance the reference by one clock using the current inputs.
    task automatic model_step();
        if (!rst_n) begin
            foreach (m_req[i]) begin m_req[i] = 0; m_ins[i] = 0; end
            m_rv = 0; m_iv = 0; m_pend = 0; m_ri = 0; m_ii = 0;
        end else if (clear_all) begin
            foreach (m_req[i]) begin m_req[i] = 0; m_ins[i] = 0; end
            m_pend = 0; m_iv = 0;
            if (ack) m_rv = 0;
        end else begin
            int  idx = int'(wr_idx);
            bit  chg = wr_en && idx < NS &&
                       (m_req[idx % NS] != wr_status[0] || m_ins[idx % NS] != wr_status[1]);
            if (ack) begin m_rv = 0; m_pend = 0; end
            if (chg) begin
                m_req[idx] = wr_status[0];
                m_ins[idx] = wr_status[1];
                m_rv = 0; m_iv = 0;
                for (int s = 0; s < NS; s++) begin
                    if (m_ins[s]) begin m_rv = 0; m_iv = 1; m_ii = s; end
                    if (m_req[s]) begin m_rv = 1; m_ri = s; end
                end
                m_pend = m_rv;
            end
        end
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Full output compare against the reference.
    task automatic compare(string tag);
        check({tag, " req_valid"}, req_valid, m_rv);
        if (m_rv) check({tag, " req_idx"}, req_idx, m_ri);
        check({tag, " ins_valid"}, ins_valid, m_iv);
        if (m_iv) check({tag, " ins_idx"}, ins_idx, m_ii);
        check({tag, " irq_pending"}, irq_pending, m_pend);
    endtask

    // One cycle: drive at negedge, clock, compare at the next negedge.
    task automatic cyc(string tag, bit we, int idx, bit [1:0] st, bit clr, bit ak);
        wr_en = we; wr_idx = AW'(idx); wr_status = st; clear_all = clr; ack = ak;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; clear_all = 0; ack = 0;
        compare(tag);
    endtask

    initial begin
        rst_n = 0; wr_en = 0; wr_idx = '0; wr_status = '0; clear_all = 0; ack = 0;
        @(negedge clk);
        repeat (3) cyc("R1", 0, 0, 2'b00, 0, 0);
        check("R1 reset req_valid", req_valid, 0);
        check("R1 reset pending", irq_pending, 0);
        rst_n = 1;

        cyc("R2", 1, 1, 2'b01, 0, 0);
        check("R2 req slot1", req_idx, 1);
        check("R7 pending", irq_pending, 1);
        cyc("R4", 1, 3, 2'b01, 0, 0);
        check("R4 later requester", req_idx, 3);
        cyc("R5", 1, 2, 2'b10, 0, 0);
        check("R5 ins slot2", ins_idx, 2);
        check("R5 req above ins", req_idx, 3);
        cyc("R5", 1, 3, 2'b00, 0, 0);
        check("R5 slot1 masked", req_valid, 0);
        check("R7 no pending", irq_pending, 0);

        cyc("R8", 1, 1, 2'b10, 1, 0);
        check("R8 ins dropped", ins_valid, 0);
        cyc("R8", 1, 1, 2'b01, 0, 0);
        check("R8 write after clear seen", req_idx, 1);
        cyc("R8", 0, 0, 2'b00, 1, 0);

        cyc("R6", 1, 0, 2'b11, 0, 0);
        check("R6 both req", req_idx, 0);
        check("R6 both ins", ins_idx, 0);
        cyc("R9", 0, 0, 2'b00, 0, 1);
        check("R9 ack drops req", req_valid, 0);
        cyc("R3", 1, 0, 2'b11, 0, 0);
        check("R3 same status no rescan", req_valid, 0);
        cyc("R2", 1, 0, 2'b01, 0, 0);
        check("R2 changed rescans", req_valid, 1);
        cyc("R9", 1, 2, 2'b01, 0, 1);
        check("R9 write beats ack", req_idx, 2);
        cyc("R10", 1, 5, 2'b10, 0, 0);
        cyc("R10", 1, 4, 2'b11, 0, 0);
        check("R10 out of range", ins_valid, 0);
        check("R10 req held", req_idx, 2);

        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            cyc("R4", $urandom_range(0, 3) != 0, $urandom_range(0, 7),
                2'($urandom_range(0, 3)), r < 3, r > 85);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule